// File: doc/BRIEF.md
# I2C SCL Clock Divider with Prescaler

This block turns a fast module clock into the serial clock of an I2C master. A prescaler first divides the module clock by (prescale + 1), giving a slower tick. Two programmable counts then set how many ticks the SCL line spends low and how many it spends high. The block adds a fixed stretch to each phase, and the size of that stretch depends on the prescale value. Each phase therefore lasts (count + d) ticks, where d is 7, 6 or 5.

While `run` is low the divider is held idle, with SCL high, and new divider values can be set up. When `run` rises, the block begins a period with the low phase. The prescale, low and high values are sampled only at the start of each SCL period. Software can therefore change them at any time without producing a short or torn phase. Single-cycle strobes mark the falling and rising edges of SCL, so that a bit-level engine can shift data in step with the clock.

Top module: `scl_divider`

## Requirements
- R1: While reset is asserted and just after it, `scl_o` is 1 and both strobes are 0.
- R2: While `run` is 0, `scl_o` stays 1, both strobes stay 0, and changes on `psc_div`, `low_count` and `high_count` have no visible effect.
- R3: The low phase of SCL lasts exactly (low_count + d) × (psc_div + 1) module clocks.
- R4: The high phase of SCL lasts exactly (high_count + d) × (psc_div + 1) module clocks.
- R5: The stretch d is 7 when psc_div = 0, 6 when psc_div = 1, and 5 when psc_div ≥ 2.
- R6: `scl_fall_o` is 1 for exactly one clock, namely the first clock in which `scl_o` is 0 in a low phase. `scl_rise_o` is 1 for exactly one clock, namely the first clock in which `scl_o` is 1 in a high phase. The two strobes are never 1 together.
- R7: The divider values are captured at the start of each period (each falling edge of SCL). A change made during a period affects only the next period.
- R8: Clearing `run` in the middle of a phase returns `scl_o` to 1 on the next clock edge. Setting `run` again starts a full-length low phase.
- R9: The first clock edge that sees `run` at 1 while idle drives `scl_o` to 0, so every enabled sequence begins with a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run | input | 1 | 1 runs the divider; 0 holds it idle with SCL high |
| psc_div | input | PSC_W | Prescale value; the tick rate is clk / (psc_div + 1) |
| low_count | input | CNT_W | Low phase count, in ticks, before the stretch is added |
| high_count | input | CNT_W | High phase count, in ticks, before the stretch is added |
| scl_o | output | 1 | SCL level |
| scl_fall_o | output | 1 | One-clock strobe at the start of each low phase |
| scl_rise_o | output | 1 | One-clock strobe at the start of each high phase |

## Verification
The hardest case to reach is a register change that arrives in the middle of a period. Such a change must leave the running low and high phases untouched and must govern the following period in full. The stimulus enables the divider with one random setting. Right after the first falling edge it drives a second, unrelated setting, then measures two whole periods and checks each against the setting that was present at its own falling edge. A second directed case drops `run` a few clocks into a low phase with a large prescale. It then re-enables and checks that the prescaler residue has not shortened the new low phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Phase stretch in prescaled ticks, selected by the prescale value
  localparam int unsigned STRETCH_P0 = 7;
  localparam int unsigned STRETCH_P1 = 6;
  localparam int unsigned STRETCH_PN = 5;

endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  logic [PSC_W-1:0] pcnt_q;
  logic [PSC_W-1:0] pcnt_d;

  assign tick = en && (pcnt_q == psc);

  always_comb begin
    if (!en || tick) pcnt_d = '0;
    else             pcnt_d = pcnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: the prescale counter never runs past the captured prescale value
  a_r3_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pcnt_q <= psc));

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import sclgen_pkg::*;
#(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic [PSC_W-1:0] psc_cur,
  output logic             active,
  output logic             scl,
  output logic             fall_stb,
  output logic             rise_stb
);

  localparam int unsigned LEN_W = CNT_W + 1;

  scl_phase_e       state_q, state_d;
  logic [LEN_W-1:0] ph_cnt_q, ph_cnt_d;
  logic [PSC_W-1:0] psc_s_q;
  logic [CNT_W-1:0] low_s_q, high_s_q;
  logic             scl_q, scl_d;
  logic             fall_q, fall_d;
  logic             rise_q, rise_d;
  logic             load;
  logic [LEN_W-1:0] cur_len;
  logic             last_tick;

  function automatic logic [LEN_W-1:0] phase_len(
    input logic [CNT_W-1:0] cnt,
    input logic [PSC_W-1:0] p
  );
    logic [LEN_W-1:0] off;
    if (p == '0)                 off = LEN_W'(STRETCH_P0);
    else if (p == PSC_W'(1))     off = LEN_W'(STRETCH_P1);
    else                         off = LEN_W'(STRETCH_PN);
    return LEN_W'(cnt) + off;
  endfunction

  assign cur_len   = (state_q == PH_HIGH) ? phase_len(high_s_q, psc_s_q)
                                          : phase_len(low_s_q, psc_s_q);
  assign last_tick = tick && (ph_cnt_q == cur_len - LEN_W'(1));

  always_comb begin
    state_d  = state_q;
    ph_cnt_d = ph_cnt_q;
    scl_d    = scl_q;
    fall_d   = 1'b0;
    rise_d   = 1'b0;
    load     = 1'b0;
    if (!run) begin
      state_d  = PH_IDLE;
      ph_cnt_d = '0;
      scl_d    = 1'b1;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d  = PH_LOW;
          ph_cnt_d = '0;
          scl_d    = 1'b0;
          fall_d   = 1'b1;
          load     = 1'b1;
        end
        PH_LOW: begin
          if (last_tick) begin
            state_d  = PH_HIGH;
            ph_cnt_d = '0;
            scl_d    = 1'b1;
            rise_d   = 1'b1;
          end else if (tick) begin
            ph_cnt_d = ph_cnt_q + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (last_tick) begin
            state_d  = PH_LOW;
            ph_cnt_d = '0;
            scl_d    = 1'b0;
            fall_d   = 1'b1;
            load     = 1'b1;
          end else if (tick) begin
            ph_cnt_d = ph_cnt_q + LEN_W'(1);
          end
        end
        default: begin
          state_d  = PH_IDLE;
          ph_cnt_d = '0;
          scl_d    = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      ph_cnt_q <= '0;
      scl_q    <= 1'b1;
      fall_q   <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      ph_cnt_q <= ph_cnt_d;
      scl_q    <= scl_d;
      fall_q   <= fall_d;
      rise_q   <= rise_d;
    end
  end

  // Shadow copies of the divider settings, loaded only at a period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_s_q  <= '0;
      low_s_q  <= '0;
      high_s_q <= '0;
    end else if (load) begin
      psc_s_q  <= psc_in;
      low_s_q  <= low_in;
      high_s_q <= high_in;
    end
  end

  assign psc_cur  = psc_s_q;
  assign active   = (state_q != PH_IDLE);
  assign scl      = scl_q;
  assign fall_stb = fall_q;
  assign rise_stb = rise_q;

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_q && !fall_q && !rise_q));

  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_q, rise_q}));

  a_r6_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fall_q) |-> $fell(scl_q));

  a_r6_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_q) |-> $rose(scl_q));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW) |=> ($stable(psc_s_q) && $stable(low_s_q) && $stable(high_s_q)));

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |-> (ph_cnt_q < cur_len));

endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_div,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  output logic             scl_o,
  output logic             scl_fall_o,
  output logic             scl_rise_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tick;
  logic             active;
  logic [PSC_W-1:0] psc_cur;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sclgen_prescale #(.PSC_W(PSC_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (active),
    .psc   (psc_cur),
    .tick  (tick)
  );

  sclgen_phase #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .tick     (tick),
    .psc_in   (psc_div),
    .low_in   (low_count),
    .high_in  (high_count),
    .psc_cur  (psc_cur),
    .active   (active),
    .scl      (scl_o),
    .fall_stb (scl_fall_o),
    .rise_stb (scl_rise_o)
  );

endmodule

// File: tb/test_scl_divider.sv
module test_scl_divider;

  localparam int unsigned PSC_W = 8;
  localparam int unsigned CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             run;
  logic [PSC_W-1:0] psc_div;
  logic [CNT_W-1:0] low_count;
  logic [CNT_W-1:0] high_count;
  logic             scl_o;
  logic             scl_fall_o;
  logic             scl_rise_o;

  int n_tests;
  int n_fail;
  bit done;

  scl_divider #(.PSC_W(PSC_W), .CNT_W(CNT_W)) i_scl_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .psc_div    (psc_div),
    .low_count  (low_count),
    .high_count (high_count),
    .scl_o      (scl_o),
    .scl_fall_o (scl_fall_o),
    .scl_rise_o (scl_rise_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int stretch(input int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  function automatic int phase_clocks(input int cnt, input int p);
    return (cnt + stretch(p)) * (p + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count consecutive samples at level lvl; returns on the first differing sample
  task automatic measure(input logic lvl, output int n, output int bad);
    n = 0;
    bad = 0;
    while (scl_o == lvl && n < 100000) begin
      n++;
      if (n > 1 && (scl_fall_o || scl_rise_o)) bad++;
      @(negedge clk);
    end
  endtask

  // Enable with setting A, optionally switch to B just after the first fall,
  // then check two full periods against the setting present at each fall.
  task automatic two_periods(input int pa, input int la, input int ha,
                             input int pb, input int lb, input int hb);
    int n;
    int bad;
    psc_div    = PSC_W'(pa);
    low_count  = CNT_W'(la);
    high_count = CNT_W'(ha);
    run        = 1'b1;
    @(negedge clk);
    check(scl_o == 1'b0, "R9 first phase low", int'(scl_o), 0);
    check(scl_fall_o == 1'b1, "R6 fall strobe at start", int'(scl_fall_o), 1);
    psc_div    = PSC_W'(pb);
    low_count  = CNT_W'(lb);
    high_count = CNT_W'(hb);
    measure(1'b0, n, bad);
    check(n == phase_clocks(la, pa), "R3/R5 low length", n, phase_clocks(la, pa));
    check(scl_rise_o == 1'b1 && bad == 0, "R6 rise strobe", int'(scl_rise_o), 1);
    measure(1'b1, n, bad);
    check(n == phase_clocks(ha, pa), "R4/R7 high length (old setting)", n, phase_clocks(ha, pa));
    check(scl_fall_o == 1'b1 && bad == 0, "R6 fall strobe", int'(scl_fall_o), 1);
    measure(1'b0, n, bad);
    check(n == phase_clocks(lb, pb), "R7/R3 low length (new setting)", n, phase_clocks(lb, pb));
    measure(1'b1, n, bad);
    check(n == phase_clocks(hb, pb), "R7/R4 high length (new setting)", n, phase_clocks(hb, pb));
    run = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b1, "R8 disable returns high", int'(scl_o), 1);
    @(negedge clk);
  endtask

  initial begin
    int s;
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    s = $urandom(32'h5eed);
    rst_n = 1'b0;
    run = 1'b0;
    psc_div = '0;
    low_count = '0;
    high_count = '0;
    repeat (3) @(negedge clk);
    check(scl_o == 1'b1 && !scl_fall_o && !scl_rise_o, "R1 reset state", int'(scl_o), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(scl_o == 1'b1 && !scl_fall_o && !scl_rise_o, "R1 after reset", int'(scl_o), 1);

    // R2: inputs ignored while run is low
    begin
      int bad2;
      bad2 = 0;
      for (int i = 0; i < 40; i++) begin
        psc_div    = PSC_W'($urandom % 256);
        low_count  = CNT_W'($urandom % 256);
        high_count = CNT_W'($urandom % 256);
        @(negedge clk);
        if (!scl_o || scl_fall_o || scl_rise_o) bad2++;
      end
      check(bad2 == 0, "R2 idle while disabled", bad2, 0);
    end

    // R5 directed: stretch for psc 0, 1, 2 and a larger value
    two_periods(0, 0, 0, 0, 0, 0);
    two_periods(1, 3, 2, 1, 3, 2);
    two_periods(2, 1, 4, 2, 1, 4);
    two_periods(7, 2, 0, 7, 2, 0);

    // R7 directed: mid-period change across stretch classes
    two_periods(0, 10, 3, 3, 1, 6);
    two_periods(4, 2, 2, 1, 9, 0);

    // R8 directed: drop run mid low phase, then restart full length
    begin
      int n;
      int bad;
      psc_div = PSC_W'(6);
      low_count = CNT_W'(3);
      high_count = CNT_W'(1);
      run = 1'b1;
      repeat (5) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      check(scl_o == 1'b1 && !scl_fall_o && !scl_rise_o, "R8 abort mid phase", int'(scl_o), 1);
      psc_div = PSC_W'(2);
      low_count = CNT_W'(4);
      run = 1'b1;
      @(negedge clk);
      measure(1'b0, n, bad);
      check(n == phase_clocks(4, 2), "R8 restart full low", n, phase_clocks(4, 2));
      run = 1'b0;
      repeat (2) @(negedge clk);
    end

    // Random mix
    for (int k = 0; k < 12; k++) begin
      two_periods($urandom % 8, $urandom % 20, $urandom % 20,
                  $urandom % 8, $urandom % 20, $urandom % 20);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule